// File: doc/BRIEF.md
# Per-Processor Interrupt Acknowledge Unit

This unit sits between a set of interrupt sources and one processor's interrupt line. It keeps two bit sets over the sources. The pending set holds requests that have been accepted but not yet taken. The in-service set holds requests the processor has taken and not yet finished. Each source presents its own priority, vector and sensitivity on input buses. The unit also keeps an activity flag for every source, a 4-bit task priority threshold and a spurious vector.

A source's request pulse is accepted only when its priority beats the threshold. The processor reads a vector through the acknowledge port. It returns the vector through the end-of-interrupt port when it has finished with the request. The interrupt line is recomputed after each acknowledge and end-of-interrupt by comparing the best pending priority with the best in-service priority.

Top module: `iack_unit`

## Requirements
- R1: After reset the pending, in-service and activity sets are empty, `irq_o` is low, the task priority reads 15, and the spurious vector is 0xFF.
- R2: A request pulse on `raise_i[k]` is accepted only when the 5-bit priority of source k is strictly greater than the task priority. A request that fails this test leaves the pending set unchanged.
- R3: A request is ignored while that source is already pending or its activity flag is set.
- R4: An accepted request sets the source's pending bit and activity flag at the next clock edge. It drives `irq_o` high at that edge if its priority exceeds the highest pending priority before the request, or if nothing was pending.
- R5: An acknowledge selects the pending source with the highest priority, and the lowest index wins a tie. If the source is still valid, the unit returns its vector and moves it from the pending set to the in-service set.
- R6: A valid acknowledge clears the activity flag of an edge-sensitive source (`level_i[k]`=0). A level-sensitive source (`level_i[k]`=1) keeps its flag until a `drop_i[k]` pulse clears it. `drop_i` has no effect on edge-sensitive sources.
- R7: An acknowledge whose selected source is stale returns the spurious vector, clears that source's pending bit and activity flag, and leaves the in-service set unchanged. A source is stale when its activity flag is clear or its priority is no longer above the task priority.
- R8: An acknowledge with an empty pending set returns the spurious vector and changes no state.
- R9: After an acknowledge that found a pending source, `irq_o` is low at the next edge. At the edge after that, `irq_o` is high exactly when the highest pending priority exceeds the highest in-service priority. An empty in-service set counts as lower than any priority.
- R10: An end-of-interrupt removes the in-service source with the highest priority, and the lowest index wins a tie. `irq_o` is then recomputed one edge later by the rule of R9.
- R11: An end-of-interrupt with an empty in-service set has no effect.
- R12: `tpr_we_i` loads the 4-bit task priority from `tpr_i`. `spv_we_i` loads the 8-bit spurious vector from `spv_i`.
- R13: A request and an acknowledge in the same cycle both take effect. The newly accepted source counts in the recomputation of `irq_o` that follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| raise_i | input | N_SRC | Request pulse per source |
| drop_i | input | N_SRC | Level source went inactive |
| level_i | input | N_SRC | 1 = level-sensitive source |
| prio_i | input | N_SRC*PRIO_W | Packed source priorities |
| vec_i | input | N_SRC*VEC_W | Packed source vectors |
| tpr_we_i | input | 1 | Task priority write strobe |
| tpr_i | input | TPR_W | Task priority write data |
| spv_we_i | input | 1 | Spurious vector write strobe |
| spv_i | input | VEC_W | Spurious vector write data |
| ack_i | input | 1 | Acknowledge strobe |
| eoi_i | input | 1 | End-of-interrupt strobe |
| irq_o | output | 1 | Processor interrupt line |
| ack_vec_o | output | VEC_W | Acknowledge data, valid while ack_i is high |
| tpr_o | output | TPR_W | Current task priority |
| pend_o | output | N_SRC | Pending set |
| serv_o | output | N_SRC | In-service set |
| act_o | output | N_SRC | Activity flags |

## Verification
A new request and an acknowledge can land in the same cycle. The bench provokes this with one source pending and a higher-priority request pulsed together with the acknowledge strobe. It judges the result by three things: the acknowledge must return the older source's vector, the pending and in-service sets must each hold one source after the edge, and `irq_o` must be low for one cycle and then high because of the newcomer. Acknowledge and end-of-interrupt can also be driven together. In that case both set updates apply to the in-service set.

// File: rtl/iack_pkg.sv
package iack_pkg;
  typedef enum logic [1:0] {
    ACK_IDLE  = 2'd0,
    ACK_EMPTY = 2'd1,
    ACK_SPUR  = 2'd2,
    ACK_VALID = 2'd3
  } ack_kind_e;
endpackage

// File: rtl/iack_pick.sv
module iack_pick #(
  parameter int N  = 8,
  parameter int PW = 5,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]    mask_i,
  input  logic [N*PW-1:0] prio_i,
  output logic            found_o,
  output logic [IW-1:0]   idx_o,
  output logic [PW-1:0]   max_o
);
  // ascending scan, strict compare: lowest index keeps a tie
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    max_o   = '0;
    for (int k = 0; k < N; k++) begin
      if (mask_i[k] && (!found_o || prio_i[k*PW +: PW] > max_o)) begin
        found_o = 1'b1;
        idx_o   = IW'(k);
        max_o   = prio_i[k*PW +: PW];
      end
    end
  end
endmodule

// File: rtl/iack_regs.sv
module iack_regs #(
  parameter int TW = 4,
  parameter int VW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tpr_we_i,
  input  logic [TW-1:0] tpr_i,
  input  logic          spv_we_i,
  input  logic [VW-1:0] spv_i,
  output logic [TW-1:0] tpr_o,
  output logic [VW-1:0] spv_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tpr_o <= '1;
      spv_o <= '1;
    end else begin
      if (tpr_we_i) tpr_o <= tpr_i;
      if (spv_we_i) spv_o <= spv_i;
    end
  end
endmodule

// File: rtl/iack_unit.sv
module iack_unit
  import iack_pkg::*;
#(
  parameter int N_SRC  = 8,
  parameter int PRIO_W = 5,
  parameter int VEC_W  = 8,
  parameter int TPR_W  = 4,
  localparam int IW = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [N_SRC-1:0]        raise_i,
  input  logic [N_SRC-1:0]        drop_i,
  input  logic [N_SRC-1:0]        level_i,
  input  logic [N_SRC*PRIO_W-1:0] prio_i,
  input  logic [N_SRC*VEC_W-1:0]  vec_i,
  input  logic                    tpr_we_i,
  input  logic [TPR_W-1:0]        tpr_i,
  input  logic                    spv_we_i,
  input  logic [VEC_W-1:0]        spv_i,
  input  logic                    ack_i,
  input  logic                    eoi_i,
  output logic                    irq_o,
  output logic [VEC_W-1:0]        ack_vec_o,
  output logic [TPR_W-1:0]        tpr_o,
  output logic [N_SRC-1:0]        pend_o,
  output logic [N_SRC-1:0]        serv_o,
  output logic [N_SRC-1:0]        act_o
);
  initial begin
    if (PRIO_W < TPR_W) $error("PRIO_W must cover TPR_W");
  end

  logic [N_SRC-1:0] pend_q, serv_q, act_q;
  logic [N_SRC-1:0] pend_d, serv_d, act_d;
  logic             irq_q, irq_d, recomp_q, recomp_d;
  logic [VEC_W-1:0] spv;
  logic [PRIO_W-1:0] tpr_x;

  logic              rp_found, sp_found;
  logic [IW-1:0]     rp_idx, sp_idx;
  logic [PRIO_W-1:0] rp_max, sp_max;

  iack_regs #(.TW(TPR_W), .VW(VEC_W)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tpr_we_i (tpr_we_i),
    .tpr_i    (tpr_i),
    .spv_we_i (spv_we_i),
    .spv_i    (spv_i),
    .tpr_o    (tpr_o),
    .spv_o    (spv)
  );

  iack_pick #(.N(N_SRC), .PW(PRIO_W)) u_pick_pend (
    .mask_i (pend_q), .prio_i (prio_i),
    .found_o(rp_found), .idx_o(rp_idx), .max_o(rp_max)
  );

  iack_pick #(.N(N_SRC), .PW(PRIO_W)) u_pick_serv (
    .mask_i (serv_q), .prio_i (prio_i),
    .found_o(sp_found), .idx_o(sp_idx), .max_o(sp_max)
  );

  assign tpr_x = PRIO_W'(tpr_o);

  // per-source acceptance
  logic [N_SRC-1:0] accept, beats;
  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    logic [PRIO_W-1:0] p;
    assign p         = prio_i[g*PRIO_W +: PRIO_W];
    assign accept[g] = raise_i[g] && !pend_q[g] && !act_q[g] && (p > tpr_x);
    assign beats[g]  = !rp_found || (p > rp_max);

    // R2
    low_prio_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (raise_i[g] && !pend_q[g] && (p <= tpr_x)) |=> !pend_q[g]);
  end

  logic acc_hi;
  assign acc_hi = |(accept & beats);

  // acknowledge decision
  ack_kind_e         kind;
  logic [PRIO_W-1:0] sel_prio;
  always_comb begin
    sel_prio = prio_i[rp_idx*PRIO_W +: PRIO_W];
    if (!ack_i)                                  kind = ACK_IDLE;
    else if (!rp_found)                          kind = ACK_EMPTY;
    else if (!act_q[rp_idx] || sel_prio <= tpr_x) kind = ACK_SPUR;
    else                                         kind = ACK_VALID;
  end

  assign ack_vec_o = (kind == ACK_VALID) ? vec_i[rp_idx*VEC_W +: VEC_W] : spv;

  logic ack_taken, eoi_taken;
  assign ack_taken = (kind == ACK_SPUR) || (kind == ACK_VALID);
  assign eoi_taken = eoi_i && sp_found;

  always_comb begin
    pend_d = pend_q | accept;
    serv_d = serv_q;
    act_d  = (act_q | accept) & ~(drop_i & level_i);
    if (ack_taken) pend_d[rp_idx] = 1'b0;
    if (eoi_taken) serv_d[sp_idx] = 1'b0;
    if (kind == ACK_VALID) begin
      serv_d[rp_idx] = 1'b1;
      if (!level_i[rp_idx]) act_d[rp_idx] = 1'b0;
    end
    if (kind == ACK_SPUR) act_d[rp_idx] = 1'b0;
  end

  assign recomp_d = ack_taken || eoi_taken;

  always_comb begin
    if (ack_taken)     irq_d = 1'b0;
    else if (recomp_q) irq_d = (rp_found && (!sp_found || rp_max > sp_max)) || acc_hi;
    else               irq_d = irq_q || acc_hi;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q   <= '0;
      serv_q   <= '0;
      act_q    <= '0;
      irq_q    <= 1'b0;
      recomp_q <= 1'b0;
    end else begin
      pend_q   <= pend_d;
      serv_q   <= serv_d;
      act_q    <= act_d;
      irq_q    <= irq_d;
      recomp_q <= recomp_d;
    end
  end

  assign irq_o  = irq_q;
  assign pend_o = pend_q;
  assign serv_o = serv_q;
  assign act_o  = act_q;

  // R8
  empty_ack_spur_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && pend_q == '0) |-> (ack_vec_o == spv));

  // R9
  ack_drops_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && pend_q != '0) |=> !irq_o);

  // R11
  empty_eoi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoi_i && !ack_i && serv_q == '0) |=> (serv_q == '0));

  // R10
  eoi_one_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoi_i && !ack_i && serv_q != '0) |=>
      ($countones(serv_q) == $countones($past(serv_q)) - 1));
endmodule

// File: tb/iack_unit_bench.sv
module iack_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 8;
  localparam int PW = 5;
  localparam int VW = 8;
  localparam int TW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [N-1:0]    raise, drop, level;
  logic [PW-1:0]   pr [N];
  logic [VW-1:0]   vc [N];
  logic [N*PW-1:0] prio_bus;
  logic [N*VW-1:0] vec_bus;
  logic            tpr_we, spv_we, ack, eoi;
  logic [TW-1:0]   tpr_d;
  logic [VW-1:0]   spv_d;
  logic            irq;
  logic [VW-1:0]   ack_vec;
  logic [TW-1:0]   tpr_q;
  logic [N-1:0]    pend, serv, act;

  for (genvar g = 0; g < N; g++) begin : g_bus
    assign prio_bus[g*PW +: PW] = pr[g];
    assign vec_bus[g*VW +: VW]  = vc[g];
  end

  iack_unit #(.N_SRC(N), .PRIO_W(PW), .VEC_W(VW), .TPR_W(TW)) u_iack_unit (
    .clk_i(clk), .rst_ni(rst_n),
    .raise_i(raise), .drop_i(drop), .level_i(level),
    .prio_i(prio_bus), .vec_i(vec_bus),
    .tpr_we_i(tpr_we), .tpr_i(tpr_d),
    .spv_we_i(spv_we), .spv_i(spv_d),
    .ack_i(ack), .eoi_i(eoi),
    .irq_o(irq), .ack_vec_o(ack_vec), .tpr_o(tpr_q),
    .pend_o(pend), .serv_o(serv), .act_o(act)
  );

  int total = 0;
  int bad = 0;

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h exp %h", req, got, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_raise(input int k);
    raise[k] = 1'b1;
    cyc();
    raise = '0;
  endtask

  task automatic do_drop(input int k);
    drop[k] = 1'b1;
    cyc();
    drop = '0;
  endtask

  task automatic do_ack(output logic [VW-1:0] v);
    ack = 1'b1;
    #1 v = ack_vec;
    cyc();
    ack = 1'b0;
  endtask

  task automatic do_eoi();
    eoi = 1'b1;
    cyc();
    eoi = 1'b0;
  endtask

  task automatic set_tpr(input logic [TW-1:0] v);
    tpr_we = 1'b1; tpr_d = v;
    cyc();
    tpr_we = 1'b0;
  endtask

  task automatic t_reset();
    logic [VW-1:0] v;
    chk("R1 irq", 32'(irq), 0);
    chk("R1 pend", 32'(pend), 0);
    chk("R1 serv", 32'(serv), 0);
    chk("R1 act", 32'(act), 0);
    chk("R1 tpr", 32'(tpr_q), 15);
    do_ack(v);
    chk("R1 R8 spurious vector", 32'(v), 32'hFF);
    chk("R8 pend unchanged", 32'(pend), 0);
    chk("R8 serv unchanged", 32'(serv), 0);
  endtask

  task automatic t_regs();
    set_tpr(4'hA);
    chk("R12 tpr", 32'(tpr_q), 32'hA);
    spv_we = 1'b1; spv_d = 8'h3C;
    cyc();
    spv_we = 1'b0;
  endtask

  task automatic t_accept();
    logic [VW-1:0] v;
    set_tpr(4'd5);
    pr[2] = 5'd5;
    do_raise(2);
    chk("R2 equal prio dropped", 32'(pend), 0);
    chk("R2 irq stays low", 32'(irq), 0);
    pr[2] = 5'd6;
    do_raise(2);
    chk("R2 accepted", 32'(pend), 32'h04);
    chk("R4 act set", 32'(act), 32'h04);
    chk("R4 irq", 32'(irq), 1);
    do_raise(2);
    chk("R3 pending re-raise", 32'(pend), 32'h04);
    do_ack(v);
    chk("R5 vector", 32'(v), 32'h42);
    chk("R5 pend", 32'(pend), 0);
    chk("R5 serv", 32'(serv), 32'h04);
    chk("R6 edge act cleared", 32'(act), 0);
    chk("R9 irq low", 32'(irq), 0);
    cyc();
    chk("R9 recompute low", 32'(irq), 0);
    do_eoi();
    chk("R10 serv", 32'(serv), 0);
    do_eoi();
    chk("R11 empty eoi", 32'(serv), 0);
    chk("R11 pend", 32'(pend), 0);
  endtask

  task automatic t_tie();
    logic [VW-1:0] v;
    set_tpr(4'd0);
    pr[6] = 5'd3; pr[4] = 5'd9; pr[1] = 5'd9;
    do_raise(6);
    chk("R4 irq on first", 32'(irq), 1);
    do_raise(4);
    do_raise(1);
    chk("R2 pend set", 32'(pend), 32'h52);
    do_ack(v);
    chk("R5 tie lowest index", 32'(v), 32'h41);
    chk("R5 serv", 32'(serv), 32'h02);
    cyc();
    chk("R9 equal prio no irq", 32'(irq), 0);
    do_ack(v);
    chk("R5 second", 32'(v), 32'h44);
    chk("R5 serv two", 32'(serv), 32'h12);
    do_eoi();
    chk("R10 tie lowest index removed", 32'(serv), 32'h10);
    cyc();
    chk("R10 irq still low", 32'(irq), 0);
    do_eoi();
    chk("R10 serv empty", 32'(serv), 0);
    cyc();
    chk("R10 irq re-raised", 32'(irq), 1);
    do_ack(v);
    chk("R5 third", 32'(v), 32'h46);
    do_eoi();
    chk("R10 clean", 32'(serv), 0);
  endtask

  task automatic t_level();
    logic [VW-1:0] v;
    level[3] = 1'b1; pr[3] = 5'd7;
    do_raise(3);
    chk("R4 level act", 32'(act), 32'h08);
    do_ack(v);
    chk("R5 level vector", 32'(v), 32'h43);
    chk("R6 level act kept", 32'(act), 32'h08);
    do_raise(3);
    chk("R3 active re-raise", 32'(pend), 0);
    do_drop(3);
    chk("R6 drop clears", 32'(act), 0);
    do_eoi();
    chk("R10 level done", 32'(serv), 0);
  endtask

  task automatic t_stale();
    logic [VW-1:0] v;
    level[5] = 1'b1; pr[5] = 5'd8;
    do_raise(5);
    do_drop(5);
    chk("R6 act cleared while pending", 32'(act), 0);
    do_ack(v);
    chk("R7 inactive spurious", 32'(v), 32'h3C);
    chk("R7 pend cleared", 32'(pend), 0);
    chk("R7 serv unchanged", 32'(serv), 0);
    pr[7] = 5'd4;
    do_raise(7);
    chk("R2 edge accepted", 32'(pend), 32'h80);
    set_tpr(4'd6);
    do_ack(v);
    chk("R7 prio below tpr spurious", 32'(v), 32'h3C);
    chk("R7 act cleared", 32'(act), 0);
    chk("R7 pend cleared 2", 32'(pend), 0);
    chk("R7 serv unchanged 2", 32'(serv), 0);
    cyc();
    chk("R9 irq after stale", 32'(irq), 0);
  endtask

  task automatic t_same_cycle();
    logic [VW-1:0] v;
    set_tpr(4'd0);
    pr[0] = 5'd5; pr[2] = 5'd10;
    do_raise(0);
    ack = 1'b1; raise[2] = 1'b1;
    #1 v = ack_vec;
    cyc();
    ack = 1'b0; raise = '0;
    chk("R13 ack vector", 32'(v), 32'h40);
    chk("R13 pend", 32'(pend), 32'h04);
    chk("R13 serv", 32'(serv), 32'h01);
    chk("R13 irq low", 32'(irq), 0);
    cyc();
    chk("R13 irq from newcomer", 32'(irq), 1);
    do_ack(v);
    chk("R13 newcomer vector", 32'(v), 32'h42);
    do_eoi();
    do_eoi();
    chk("R13 clean", 32'(serv), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: got timeout exp finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    raise = '0; drop = '0; level = '0;
    tpr_we = 1'b0; spv_we = 1'b0; ack = 1'b0; eoi = 1'b0;
    tpr_d = '0; spv_d = '0;
    for (int k = 0; k < N; k++) begin
      pr[k] = '0;
      vc[k] = 8'h40 + 8'(k);
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_accept();
    t_tie();
    t_level();
    t_stale();
    t_same_cycle();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule